// File: doc/BRIEF.md
# Table-driven multi-process sequencer

This block is a state-machine engine whose behaviour lives entirely in a lookup memory. Every transition of a machine is one memory word. The word is addressed by three fields: a process number, the present qualifier inputs and the present state bits. Its upper part holds the next state and its lower part holds the output pattern. A state register feeds the next-state field back into the address. As a result, any algorithmic state machine chart can be run without changing the logic, provided its transition table is fully expanded (every don't-care qualifier written out as all its 0/1 combinations) and loaded into the memory.

The memory holds one 256-word page for each of eight processes, and the process select picks the page. Tables are written through a simple load port while the engine is stopped. Once the stop input is released, the engine runs a repeating loop:

- **HALT**: idle while stop is high.
- **READ**: fetch the word at the current address.
- **LATCH**: apply the next state and the output pattern.
- **SETTLE**: wait a programmable number of cycles before the next fetch.

Named transitions: HALT→READ when stop is low; READ→LATCH; LATCH→READ when the delay is zero; LATCH→SETTLE when the delay is non-zero; SETTLE→READ when the count expires. From any phase, going to HALT on stop takes priority over everything else. Any running phase goes to READ when the process select changes.

Top module: `tbl_seq_engine`

## Requirements
- R1: During and after reset, `cur_state` and `pattern` are 0 and the engine is halted until stop is low.
- R2: The read address is {process[10:8], qualifiers[7:4], state[3:0]}. A word holds the next state in bits [7:4] and the output pattern in bits [3:0].
- R3: On each step, the fetched word's upper field becomes `cur_state` and its lower field becomes `pattern`. With a zero delay, the first update lands on the third rising edge after stop is seen low, and later updates land every 2 cycles. Qualifiers are sampled in the cycle that follows an update.
- R4: A delay value D, sampled at an update, inserts D idle cycles before the next fetch, so that steps are 2+D cycles apart.
- R5: While stop is high, `pattern` holds, and `cur_state` holds unless the process select changes.
- R6: Load writes take effect only while stop is high. A write attempted while stop is low leaves the table unchanged.
- R7: A change of process select clears `cur_state` to 0 on the next edge, whether the engine is running or stopped. Any fetch in flight is discarded, and the next fetch uses the new page.
- R8: Each process page is independent. A machine loaded at page 1 runs from its own words with the same step timing.
- R9: With the heater table loaded at page 0, the engine follows that chart. The qualifiers are Lth at bit 1 and Uth at bit 0, and the state codes are ST0=00, ST1=01, ST2=11 and ST3=10. The transitions are: ST0 stays when Lth=0 and goes to ST1 when Lth=1; ST1 goes to ST2 when Lth=0 and to ST3 when Lth=1; ST2 stays when Uth=0 and goes to ST0 when Uth=1; ST3 always goes to ST0. The heater bit (pattern bit 0) is 1 in ST1 and ST2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop | input | 1 | Halts the loop; enables table loading |
| proc_sel | input | 3 | Process (page) select |
| qual | input | 4 | Input qualifiers |
| delay_cyc | input | 16 | Settle cycles after each update |
| ld_en | input | 1 | Table write strobe |
| ld_addr | input | 11 | Table write address |
| ld_data | input | 8 | Table write word |
| pattern | output | 4 | Output pattern of the last fetched word |
| cur_state | output | 4 | Present state bits |

## Verification
The hardest situations to reach are a process change while a fetch is in flight and a load attempt on the exact cycle the loop restarts. Both need the stimulus to be placed on a known phase of the loop. The bench counts edges from the release of stop so that it knows which phase is active. It changes the process select in the READ cycle that follows an update, which shows that the stale word is dropped and the state is cleared. It also holds a corrupting write to the address about to be fetched throughout the restart, and the step result shows that the write never reached the table.

// File: rtl/tbl_seq_pkg.sv
package tbl_seq_pkg;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_READ   = 2'd1,
        ST_LATCH  = 2'd2,
        ST_SETTLE = 2'd3
    } seq_phase_e;

endpackage

// File: rtl/tbl_seq_ram.sv
module tbl_seq_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/tbl_seq_settle.sv
module tbl_seq_settle #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - ONE;
        end
    end

    assign expire = (count == ONE);
endmodule

// File: rtl/tbl_seq_ctrl.sv
module tbl_seq_ctrl
    import tbl_seq_pkg::*;
#(
    parameter int PROC_W = 3,
    parameter int ST_W   = 4,
    parameter int OUT_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stop,
    input  logic [PROC_W-1:0]     proc_sel,
    input  logic                  delay_zero,
    input  logic                  dly_expire,
    input  logic [ST_W+OUT_W-1:0] rd_word,
    output logic                  rd_en,
    output logic                  dly_load,
    output logic                  dly_clear,
    output logic [PROC_W-1:0]     proc_q,
    output logic [ST_W-1:0]       state_q,
    output logic [OUT_W-1:0]      pattern_q,
    output seq_phase_e            phase
);
    seq_phase_e phase_nx;
    logic       proc_chg;
    logic       apply_word;

    assign proc_chg = (proc_sel != proc_q);

    // next-phase and strobe logic
    always_comb begin
        phase_nx   = phase;
        rd_en      = 1'b0;
        apply_word = 1'b0;
        dly_load   = 1'b0;
        dly_clear  = 1'b0;
        if (stop) begin
            phase_nx  = ST_HALT;
            dly_clear = 1'b1;
        end else if (proc_chg) begin
            phase_nx  = ST_READ;
            dly_clear = 1'b1;
        end else begin
            unique case (phase)
                ST_HALT: begin
                    phase_nx = ST_READ;
                end
                ST_READ: begin
                    rd_en    = 1'b1;
                    phase_nx = ST_LATCH;
                end
                ST_LATCH: begin
                    apply_word = 1'b1;
                    if (delay_zero) begin
                        phase_nx = ST_READ;
                    end else begin
                        dly_load = 1'b1;
                        phase_nx = ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (dly_expire) begin
                        phase_nx = ST_READ;
                    end
                end
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_HALT;
        end else begin
            phase <= phase_nx;
        end
    end

    // process tracking and state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_q  <= '0;
            state_q <= '0;
        end else begin
            proc_q <= proc_sel;
            if (proc_chg) begin
                state_q <= '0;
            end else if (apply_word) begin
                state_q <= rd_word[OUT_W +: ST_W];
            end
        end
    end

    // output pattern register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_q <= '0;
        end else if (apply_word) begin
            pattern_q <= rd_word[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/tbl_seq_engine.sv
module tbl_seq_engine
    import tbl_seq_pkg::*;
#(
    parameter int PROC_W = 3,
    parameter int QUAL_W = 4,
    parameter int ST_W   = 4,
    parameter int OUT_W  = 4,
    parameter int DLY_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            stop,
    input  logic [PROC_W-1:0]               proc_sel,
    input  logic [QUAL_W-1:0]               qual,
    input  logic [DLY_W-1:0]                delay_cyc,
    input  logic                            ld_en,
    input  logic [PROC_W+QUAL_W+ST_W-1:0]   ld_addr,
    input  logic [ST_W+OUT_W-1:0]           ld_data,
    output logic [OUT_W-1:0]                pattern,
    output logic [ST_W-1:0]                 cur_state
);
    localparam int AW = PROC_W + QUAL_W + ST_W;
    localparam int DW = ST_W + OUT_W;

    logic              ram_we;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic [DW-1:0]     rd_word;
    logic              dly_load;
    logic              dly_clear;
    logic              dly_expire;
    logic [DLY_W-1:0]  dly_cnt;
    logic [PROC_W-1:0] proc_q;
    seq_phase_e        phase;

    // loads only reach the table while the loop is stopped
    assign ram_we  = ld_en & stop;
    assign rd_addr = {proc_q, qual, cur_state};

    tbl_seq_ram #(
        .AW (AW),
        .DW (DW)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    tbl_seq_settle #(
        .CW (DLY_W)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (dly_clear),
        .load     (dly_load),
        .load_val (delay_cyc),
        .expire   (dly_expire),
        .count    (dly_cnt)
    );

    tbl_seq_ctrl #(
        .PROC_W (PROC_W),
        .ST_W   (ST_W),
        .OUT_W  (OUT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop       (stop),
        .proc_sel   (proc_sel),
        .delay_zero (delay_cyc == '0),
        .dly_expire (dly_expire),
        .rd_word    (rd_word),
        .rd_en      (rd_en),
        .dly_load   (dly_load),
        .dly_clear  (dly_clear),
        .proc_q     (proc_q),
        .state_q    (cur_state),
        .pattern_q  (pattern),
        .phase      (phase)
    );
endmodule

// File: rtl/tbl_seq_engine_chk.sv
module tbl_seq_engine_chk
    import tbl_seq_pkg::*;
#(
    parameter int PROC_W = 3,
    parameter int ST_W   = 4,
    parameter int OUT_W  = 4,
    parameter int DLY_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stop,
    input logic [PROC_W-1:0]     proc_sel,
    input logic [PROC_W-1:0]     proc_q,
    input logic [ST_W+OUT_W-1:0] rd_word,
    input logic [DLY_W-1:0]      dly_cnt,
    input seq_phase_e            phase,
    input logic [OUT_W-1:0]      pattern,
    input logic [ST_W-1:0]       cur_state
);
    p_word_applied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_LATCH && !stop && proc_sel == proc_q)
        |=> (cur_state == $past(rd_word[OUT_W +: ST_W]) &&
             pattern == $past(rd_word[OUT_W-1:0])));

    p_settle_counting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_SETTLE) |-> (dly_cnt != '0));

    p_pattern_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(pattern));

    p_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && proc_sel == proc_q) |=> $stable(cur_state));

    p_proc_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_sel != proc_q) |=> (cur_state == '0));
endmodule

bind tbl_seq_engine tbl_seq_engine_chk #(
    .PROC_W (PROC_W),
    .ST_W   (ST_W),
    .OUT_W  (OUT_W),
    .DLY_W  (DLY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (stop),
    .proc_sel  (proc_sel),
    .proc_q    (proc_q),
    .rd_word   (rd_word),
    .dly_cnt   (dly_cnt),
    .phase     (phase),
    .pattern   (pattern),
    .cur_state (cur_state)
);

// File: tb/tbl_seq_engine_test.sv
`timescale 1ns/1ps
module tbl_seq_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        stop;
    logic [2:0]  proc_sel;
    logic [3:0]  qual;
    logic [15:0] delay_cyc;
    logic        ld_en;
    logic [10:0] ld_addr;
    logic [7:0]  ld_data;
    logic [3:0]  pattern;
    logic [3:0]  cur_state;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tbl_seq_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop      (stop),
        .proc_sel  (proc_sel),
        .qual      (qual),
        .delay_cyc (delay_cyc),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .pattern   (pattern),
        .cur_state (cur_state)
    );

    // vector: {Lth, Uth, expected state[3:0], expected pattern[3:0]}
    localparam logic [9:0] VEC [16] = '{
        {2'b00, 4'd0, 4'd0}, {2'b10, 4'd1, 4'd0},
        {2'b01, 4'd3, 4'd1}, {2'b10, 4'd3, 4'd1},
        {2'b01, 4'd0, 4'd1}, {2'b11, 4'd1, 4'd0},
        {2'b10, 4'd2, 4'd1}, {2'b00, 4'd0, 4'd0},
        {2'b01, 4'd0, 4'd0}, {2'b11, 4'd1, 4'd0},
        {2'b00, 4'd3, 4'd1}, {2'b00, 4'd3, 4'd1},
        {2'b11, 4'd0, 4'd1}, {2'b10, 4'd1, 4'd0},
        {2'b11, 4'd2, 4'd1}, {2'b11, 4'd0, 4'd0}
    };

    // heater chart word: {00, next BA, 000, heater}
    function automatic logic [7:0] heater_word(input logic l, input logic u,
                                               input logic [1:0] s);
        logic [1:0] ns;
        logic       h;
        case (s)
            2'b00:   begin ns = l ? 2'b01 : 2'b00; h = 1'b0; end
            2'b01:   begin ns = l ? 2'b10 : 2'b11; h = 1'b1; end
            2'b11:   begin ns = u ? 2'b00 : 2'b11; h = 1'b1; end
            default: begin ns = 2'b00;             h = 1'b0; end
        endcase
        return {2'b00, ns, 3'b000, h};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        ld_en   = 1'b1;
        ld_addr = a;
        ld_data = d;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stop = 1'b1; proc_sel = 3'd0; qual = 4'd0;
        delay_cyc = 16'd0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        edges(3);
        chk("R1 reset state", cur_state, 0);
        chk("R1 reset pattern", pattern, 0);
        rst_n = 1'b1;
        edges(4);
        chk("R1 halted state", cur_state, 0);

        // load page 0 (heater, R2 layout) and page 1 (four-step counter)
        for (int s = 0; s < 4; s++) begin
            for (int q = 0; q < 4; q++) begin
                wr({3'd0, 4'(q), 4'(s)}, heater_word(q[1], q[0], 2'(s)));
            end
            wr({3'd1, 4'd0, 4'(s)}, {4'((s + 1) % 4), 4'(8 + s)});
        end

        // R3/R9: vector walk on the heater chart, zero delay
        for (int i = 0; i < 16; i++) begin
            qual = {2'b00, VEC[i][9:8]};
            if (i == 0) begin
                stop = 1'b0;
                edges(3);
            end else begin
                edges(2);
            end
            chk($sformatf("R3 R9 step %0d state", i), cur_state, VEC[i][7:4]);
            chk($sformatf("R3 R9 step %0d pattern", i), pattern, VEC[i][3:0]);
        end

        // R4: delay of 3 cycles; state 0 now, phase READ
        delay_cyc = 16'd3;
        qual = 4'b0010;
        edges(2);
        chk("R4 step before settle", cur_state, 1);
        qual = 4'b0000;
        edges(4);
        chk("R4 no early step", cur_state, 1);
        edges(1);
        chk("R4 step after 2+D", cur_state, 3);
        qual = 4'b0001;
        edges(5);
        chk("R4 second delayed step", cur_state, 0);
        chk("R4 second delayed pattern", pattern, 1);

        // R5: stop holds outputs
        stop = 1'b1;
        delay_cyc = 16'd0;
        qual = 4'b0010;
        edges(10);
        chk("R5 stopped state", cur_state, 0);
        chk("R5 stopped pattern", pattern, 1);

        // R6: corrupting write held through restart is ignored
        ld_en = 1'b1; ld_addr = 11'h020; ld_data = 8'hF5;
        stop = 1'b0;
        edges(3);
        ld_en = 1'b0;
        chk("R6 write ignored state", cur_state, 1);
        chk("R6 write ignored pattern", pattern, 0);

        // R7/R8: switch to page 1 in the READ cycle
        proc_sel = 3'd1;
        qual = 4'd0;
        edges(1);
        chk("R7 state cleared on switch", cur_state, 0);
        edges(2);
        chk("R8 page1 step0 state", cur_state, 1);
        chk("R8 page1 step0 pattern", pattern, 8);
        for (int k = 1; k < 4; k++) begin
            edges(2);
            chk("R8 page1 state", cur_state, (k + 1) % 4);
            chk("R8 page1 pattern", pattern, 8 + k);
        end
        edges(2);
        chk("R8 page1 wrap state", cur_state, 1);

        // R7 while stopped, R5 pattern held
        stop = 1'b1;
        proc_sel = 3'd0;
        edges(3);
        chk("R7 stopped switch state", cur_state, 0);
        chk("R5 stopped switch pattern", pattern, 8);
        qual = 4'b0010;
        stop = 1'b0;
        edges(3);
        chk("R7 new page fetch state", cur_state, 1);
        chk("R7 new page fetch pattern", pattern, 0);

        // R1: reset mid-run
        rst_n = 1'b0;
        edges(2);
        chk("R1 mid-run reset state", cur_state, 0);
        chk("R1 mid-run reset pattern", pattern, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule